// File: doc/BRIEF.md
# Quantized Perceptron Trigger Classifier

This block runs inference for a small, fixed multilayer perceptron at line rate. Every clock cycle it can take one frame of forty unsigned 6-bit features, which are a compressed hit-map image of one detector event. It returns two signed class scores, one for background and one for signal, after a fixed number of cycles. It also raises an accept flag when the signal score is larger than the background score by more than a threshold set at build time.

The network is baked into the logic. Weights and biases are integer constants computed from closed-form expressions at elaboration, so the block needs no memory initialisation and no load path. It has four hidden layers of `HID_N` neurons each. Each hidden layer ends in a clipped 4-bit rectifier. A linear two-neuron layer produces the scores. Each layer takes two register stages: one for the multiply-accumulate and one for the activation. A valid bit runs beside the data, so the output timing never depends on the data.

Top module: `qmlp_classifier`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` and `accept` are 0. Frames that were in flight when reset rose never produce an output.
- R2: With default parameters, `out_valid` is high exactly 11 cycles after each cycle with `in_valid` high. The general value is 2·NUM_HIDDEN+3 cycles. Frames may arrive on consecutive cycles, and each one yields one output.
- R3: Feature k (k = 0..39) is the unsigned value at `in_feat[6k+5:6k]`.
- R4: Weights and biases are fixed. They are numbered by layer l (0–3 hidden, 4 output), neuron o and input i.
  - The weight is ((3l + 5o + 7i + o·i) mod 16) − 8.
  - The bias is (((11l + 13o) mod 41) − 20)·4.
  - A neuron's pre-activation is its bias plus the sum of weight × input.
- R5: A hidden neuron outputs 0 when its pre-activation is negative. Otherwise it outputs the pre-activation arithmetically shifted right by 3 (`FRAC`), clipped to a maximum of 15.
- R6: The output neurons apply no activation. Output neuron 0 drives `score_bg` and output neuron 1 drives `score_sig`, both as two's-complement values.
- R7: When `out_valid` is high, `accept` equals (`score_sig` − `score_bg` > `THRESH`), with `THRESH` = 0 by default.
- R8: `accept` is 0 on every cycle where `out_valid` is 0.
- R9: When `out_valid` is high, each score's magnitude is at most HID_N·15·8 + 80. With defaults this bound is 1040.
- R10: Cycles with `in_valid` low create no output, and they do not disturb the frames around them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Frame present on `in_feat` this cycle |
| in_feat | input | 240 | Forty packed 6-bit unsigned features |
| out_valid | output | 1 | Scores and accept flag are valid |
| score_bg | output | 16 | Signed background score |
| score_sig | output | 16 | Signed signal score |
| accept | output | 1 | Signal score beats background by more than the threshold |

## Verification
The assertions assume that `in_valid` is a clean 0/1 level sampled at the clock edge. They also assume that `in_feat` is valid whenever `in_valid` is high, and that reset is held for at least one edge before traffic starts. The stimulus drives all inputs one time unit after a rising edge, so every value is settled well before the next sample. It feeds frames only outside reset, except in one sequence where reset deliberately cuts off frames already in flight. The frames cover all-zero input, all-maximum input, one active feature at each of the forty positions, back-to-back random traffic and random traffic with bubbles.

// File: rtl/qmlp_pkg.sv
package qmlp_pkg;
    localparam int FEAT_W = 6;
    localparam int ACT_W  = 4;
    localparam int WGT_W  = 4;
    localparam int BIAS_W = 12;
    localparam int ACT_MAX = (1 << ACT_W) - 1;

    // signed 4-bit weight, range -8..7
    function automatic int weight_of(input int layer, input int o, input int i);
        return ((3 * layer + 5 * o + 7 * i + o * i) % 16) - 8;
    endfunction

    // signed bias, range -80..80 (fits BIAS_W)
    function automatic int bias_of(input int layer, input int o);
        return (((11 * layer + 13 * o) % 41) - 20) * 4;
    endfunction
endpackage

// File: rtl/qmlp_dense.sv
module qmlp_dense
    import qmlp_pkg::*;
#(
    parameter int LAYER = 0,
    parameter int N_IN  = 40,
    parameter int N_OUT = 8,
    parameter int IN_W  = 6,
    parameter int FRAC  = 3
) (
    input  logic                      clk,
    input  logic [N_IN*IN_W-1:0]      in_vec,
    output logic [N_OUT*ACT_W-1:0]    out_act
);
    localparam int ACC_W = IN_W + WGT_W + $clog2(N_IN) + 2;

    typedef struct packed {
        logic [N_OUT-1:0][ACC_W-1:0] acc;
        logic [N_OUT-1:0][ACT_W-1:0] act;
    } dense_st_t;

    dense_st_t st_d, st_q;

    always_comb begin
        int                       sum;
        logic signed [ACC_W-1:0]  pre;
        logic signed [ACC_W-1:0]  shf;
        st_d = st_q;
        for (int o = 0; o < N_OUT; o++) begin
            // stage 1: multiply-accumulate with constant weights
            sum = bias_of(LAYER, o);
            for (int i = 0; i < N_IN; i++) begin
                sum = sum + weight_of(LAYER, o, i) * int'(in_vec[i*IN_W +: IN_W]);
            end
            st_d.acc[o] = ACC_W'(sum);
            // stage 2: clipped rectifier on the registered sum
            pre = $signed(st_q.acc[o]);
            shf = pre >>> FRAC;
            if (pre[ACC_W-1])
                st_d.act[o] = '0;
            else if (int'(shf) > ACT_MAX)
                st_d.act[o] = ACT_W'(ACT_MAX);
            else
                st_d.act[o] = shf[ACT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_act = st_q.act;
endmodule

// File: rtl/qmlp_head.sv
module qmlp_head
    import qmlp_pkg::*;
#(
    parameter int LAYER   = 4,
    parameter int N_IN    = 8,
    parameter int SCORE_W = 16,
    parameter int THRESH  = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sc_valid,
    input  logic [N_IN*ACT_W-1:0]   in_act,
    output logic [SCORE_W-1:0]      score_bg,
    output logic [SCORE_W-1:0]      score_sig,
    output logic                    accept
);
    typedef struct packed {
        logic [1:0][SCORE_W-1:0] sc;
        logic [SCORE_W-1:0]      bg;
        logic [SCORE_W-1:0]      sig;
        logic                    acc;
    } head_st_t;

    head_st_t st_d, st_q;

    always_comb begin
        int sum;
        int diff;
        st_d = st_q;
        for (int o = 0; o < 2; o++) begin
            sum = bias_of(LAYER, o);
            for (int i = 0; i < N_IN; i++) begin
                sum = sum + weight_of(LAYER, o, i) * int'(in_act[i*ACT_W +: ACT_W]);
            end
            st_d.sc[o] = SCORE_W'(sum);
        end
        diff     = int'($signed(st_q.sc[1])) - int'($signed(st_q.sc[0]));
        st_d.bg  = st_q.sc[0];
        st_d.sig = st_q.sc[1];
        st_d.acc = sc_valid && (diff > THRESH);
    end

    always_ff @(posedge clk) begin
        st_q.sc  <= st_d.sc;
        st_q.bg  <= st_d.bg;
        st_q.sig <= st_d.sig;
        st_q.acc <= rst ? 1'b0 : st_d.acc;
    end

    assign score_bg  = st_q.bg;
    assign score_sig = st_q.sig;
    assign accept    = st_q.acc;
endmodule

// File: rtl/qmlp_classifier.sv
module qmlp_classifier
    import qmlp_pkg::*;
#(
    parameter int NUM_FEAT   = 40,
    parameter int NUM_HIDDEN = 4,
    parameter int HID_N      = 8,
    parameter int FRAC       = 3,
    parameter int SCORE_W    = 16,
    parameter int THRESH     = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NUM_FEAT*FEAT_W-1:0] in_feat,
    output logic                       out_valid,
    output logic [SCORE_W-1:0]         score_bg,
    output logic [SCORE_W-1:0]         score_sig,
    output logic                       accept
);
    // input register + two stages per hidden layer + score + final
    localparam int LAT = 2 * NUM_HIDDEN + 3;

    typedef struct packed {
        logic [NUM_FEAT*FEAT_W-1:0] feat;
        logic [LAT-1:0]             vpipe;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.feat  = in_feat;
        st_d.vpipe = {st_q.vpipe[LAT-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        st_q.feat  <= st_d.feat;
        st_q.vpipe <= rst ? '0 : st_d.vpipe;
    end

    logic [NUM_HIDDEN-1:0][HID_N*ACT_W-1:0] act_bus;

    for (genvar l = 0; l < NUM_HIDDEN; l++) begin : g_hidden
        if (l == 0) begin : g_first
            qmlp_dense #(
                .LAYER(0), .N_IN(NUM_FEAT), .N_OUT(HID_N),
                .IN_W(FEAT_W), .FRAC(FRAC)
            ) u_dense (
                .clk(clk), .in_vec(st_q.feat), .out_act(act_bus[0])
            );
        end else begin : g_next
            qmlp_dense #(
                .LAYER(l), .N_IN(HID_N), .N_OUT(HID_N),
                .IN_W(ACT_W), .FRAC(FRAC)
            ) u_dense (
                .clk(clk), .in_vec(act_bus[l-1]), .out_act(act_bus[l])
            );
        end
    end

    qmlp_head #(
        .LAYER(NUM_HIDDEN), .N_IN(HID_N), .SCORE_W(SCORE_W), .THRESH(THRESH)
    ) u_head (
        .clk(clk), .rst(rst), .sc_valid(st_q.vpipe[LAT-2]),
        .in_act(act_bus[NUM_HIDDEN-1]),
        .score_bg(score_bg), .score_sig(score_sig), .accept(accept)
    );

    assign out_valid = st_q.vpipe[LAT-1];
endmodule

// File: rtl/qmlp_classifier_chk.sv
module qmlp_classifier_chk #(
    parameter int LAT     = 11,
    parameter int SCORE_W = 16,
    parameter int BOUND   = 1040,
    parameter int THRESH  = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               out_valid,
    input logic               accept,
    input logic [SCORE_W-1:0] score_bg,
    input logic [SCORE_W-1:0] score_sig
);
    logic [LAT-1:0] shadow_q;
    logic           rst_seen_q;

    always_ff @(posedge clk) begin
        shadow_q   <= rst ? '0 : {shadow_q[LAT-2:0], in_valid};
        rst_seen_q <= rst;
    end

    int sig_i, bg_i;
    assign sig_i = int'($signed(score_sig));
    assign bg_i  = int'($signed(score_bg));

    // R1: outputs idle on the cycle after a reset edge
    a_r1_reset_idle: assert property (@(posedge clk)
        rst_seen_q |-> (!out_valid && !accept));

    // R2 / R10: output valid follows input valid by the fixed latency
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == shadow_q[LAT-1]);

    // R7: accept decision on valid outputs
    a_r7_accept_rule: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (accept == ((sig_i - bg_i) > THRESH)));

    // R8: no accept without valid
    a_r8_accept_gated: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !accept);

    // R9: score magnitudes bounded
    a_r9_score_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sig_i <= BOUND && sig_i >= -BOUND &&
                       bg_i <= BOUND && bg_i >= -BOUND));
endmodule

bind qmlp_classifier qmlp_classifier_chk #(
    .LAT(LAT), .SCORE_W(SCORE_W), .BOUND(HID_N * 15 * 8 + 80), .THRESH(THRESH)
) u_chk (.*);

// File: tb/qmlp_classifier_tb.sv
module qmlp_classifier_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NF     = 40;
    localparam int NH     = 4;
    localparam int HN     = 8;
    localparam int LAT    = 2 * NH + 3;
    localparam int THRESH = 0;
    localparam int BOUND  = HN * 15 * 8 + 80;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [239:0] in_feat = '0;
    logic         out_valid, accept;
    logic [15:0]  score_bg, score_sig;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int q_bg[$];
    int q_sig[$];
    logic [LAT-1:0] vhist = '0;

    qmlp_classifier u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_feat(in_feat),
        .out_valid(out_valid), .score_bg(score_bg), .score_sig(score_sig),
        .accept(accept)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // weights and biases as given in R4
    function automatic int w_of(input int l, input int o, input int i);
        return ((3 * l + 5 * o + 7 * i + o * i) % 16) - 8;
    endfunction
    function automatic int b_of(input int l, input int o);
        return (((11 * l + 13 * o) % 41) - 20) * 4;
    endfunction
    // R5 rectifier
    function automatic int relu4(input int s);
        if (s < 0) return 0;
        if ((s >>> 3) > 15) return 15;
        return s >>> 3;
    endfunction

    task automatic ref_model(input int f[NF], output int bg, output int sig);
        int a[HN];
        int n[HN];
        int s;
        for (int o = 0; o < HN; o++) begin
            s = b_of(0, o);
            for (int i = 0; i < NF; i++) s += w_of(0, o, i) * f[i];
            a[o] = relu4(s);
        end
        for (int l = 1; l < NH; l++) begin
            for (int o = 0; o < HN; o++) begin
                s = b_of(l, o);
                for (int i = 0; i < HN; i++) s += w_of(l, o, i) * a[i];
                n[o] = relu4(s);
            end
            a = n;
        end
        bg = b_of(NH, 0);
        sig = b_of(NH, 1);
        for (int i = 0; i < HN; i++) begin
            bg  += w_of(NH, 0, i) * a[i];
            sig += w_of(NH, 1, i) * a[i];
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int f[NF], input bit v);
        int bg, sig;
        @(posedge clk); #1;
        in_valid = v;
        for (int k = 0; k < NF; k++) in_feat[k*6 +: 6] = 6'(f[k]);   // R3 packing
        if (v) begin
            ref_model(f, bg, sig);
            q_bg.push_back(bg);
            q_sig.push_back(sig);
        end
    endtask

    // independent valid history for R2 / R10
    always @(posedge clk) begin
        if (rst) vhist <= '0;
        else     vhist <= {vhist[LAT-2:0], in_valid};
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin
        int ebg, esig;
        if (rst) begin
            check("R1 out_valid in reset", int'(out_valid), 0);
            check("R1 accept in reset", int'(accept), 0);
        end else begin
            check("R2/R10 out_valid timing", int'(out_valid), int'(vhist[LAT-1]));
            if (out_valid) begin
                if (q_bg.size() == 0) begin
                    check("R2 unexpected output", 1, 0);
                end else begin
                    ebg = q_bg.pop_front();
                    esig = q_sig.pop_front();
                    check("R6 score_bg", int'($signed(score_bg)), ebg);
                    check("R6 score_sig", int'($signed(score_sig)), esig);
                    check("R7 accept", int'(accept), int'((esig - ebg) > THRESH));
                    check("R9 bound", int'(esig <= BOUND && esig >= -BOUND &&
                                           ebg <= BOUND && ebg >= -BOUND), 1);
                end
            end else begin
                check("R8 accept idle", int'(accept), 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int f[NF];
        for (int k = 0; k < NF; k++) f[k] = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R4: all-zero input, scores depend on biases alone
        send(f, 1);
        // R5: all-maximum input saturates the first layer
        for (int k = 0; k < NF; k++) f[k] = 63;
        send(f, 1);
        // R3: one active feature at each position, back to back
        for (int p = 0; p < NF; p++) begin
            for (int k = 0; k < NF; k++) f[k] = (k == p) ? 63 : 0;
            send(f, 1);
        end
        // R2: random back-to-back traffic
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < NF; k++) f[k] = int'($urandom % 64);
            send(f, 1);
        end
        // R10: random traffic with bubbles
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < NF; k++) f[k] = int'($urandom % 64);
            send(f, ($urandom % 3) == 0);
        end
        for (int n = 0; n < LAT + 4; n++) send(f, 0);
        check("R10 all frames returned", q_bg.size(), 0);

        // R1: reset while frames are in flight
        for (int n = 0; n < 5; n++) begin
            for (int k = 0; k < NF; k++) f[k] = int'($urandom % 64);
            send(f, 1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst = 1'b1;
        q_bg.delete();
        q_sig.delete();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int n = 0; n < LAT + 4; n++) send(f, 0);
        // a sparse pattern after reset still works
        for (int k = 0; k < NF; k++) f[k] = (k % 5 == 0) ? 40 : 0;
        send(f, 1);
        for (int n = 0; n < LAT + 4; n++) send(f, 0);
        check("R1 queue drained after reset", q_bg.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule